// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block copies blocks of data words from a bus-side source address space into a memory-side destination. Software never drives the individual transfers. It writes a linked list of command descriptors into memory, presents the address of the first one, and pulses a start input. The engine then reads each descriptor and performs one contiguous copy. It follows the link to the next descriptor and repeats this until it has finished a descriptor that carries the end marker. The whole list counts as one operation.

Each descriptor is four memory words, read at consecutive addresses. Word 0 gives the first source address. Word 1 gives the first destination address. Word 2 packs the word count and the bus cycle-type code. Word 3 packs the link to the next descriptor and the end marker. Every source word is fetched with a request/acknowledge handshake on the bus side and then written to memory. When the cycle type is the block code, the start address is presented only once for the whole descriptor, and both sides then advance the address themselves. A bus error aborts the chain. The engine then records which descriptor failed. When the chain ends, whether it completed or aborted, the engine pulses an interrupt and leaves a status flag that software can poll.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, busy, done_flag, err_flag, irq, bus_req and mem_req are all low.
- R2: When go is accepted, the engine reads the first descriptor from memory at head_addr, head_addr+1, head_addr+2 and head_addr+3. The memory returns mem_rdata one cycle after a read request. The descriptor fetch and the data writes share one memory port and never use it in the same cycle.
- R3: Descriptor layout. Word 0 bits [AW-1:0] hold the source address. Word 1 bits [AW-1:0] hold the destination address. Word 2 bits [CW-1:0] hold the word count and bits [21:16] hold the cycle-type code. Word 3 bit 31 is the end marker and bits [AW-1:0] hold the address of the next descriptor.
- R4: Word i of a descriptor is read on the bus from source+i, with bus_am equal to the descriptor's cycle type. It is then written to destination+i. bus_req and bus_addr stay stable until bus_ack or bus_err.
- R5: With cycle type 6'h08 (block mode), bus_addr_phase is high only on the first word of the descriptor. With any other code, bus_addr_phase is high on every word.
- R6: After a descriptor without the end marker, the engine fetches the linked descriptor. The chain ends after the first descriptor that has the end marker.
- R7: A descriptor with a count of zero produces no bus cycle and no memory write. The chain continues as usual after it.
- R8: When the end-marked descriptor completes, busy falls, done_flag is set and irq pulses high for exactly one cycle. All three happen in the same cycle.
- R9: If bus_err arrives, the failing word is not written to memory and no further descriptor is processed. err_flag is set, fail_desc_addr holds the address of the failing descriptor, busy falls and irq pulses for one cycle.
- R10: A go pulse while busy is high is ignored. The running chain, its writes and busy are unaffected.
- R11: An accepted go clears done_flag and err_flag. The two flags are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse; accepted only while idle |
| head_addr | input | AW | Memory address of the first descriptor |
| busy | output | 1 | Chain in progress |
| done_flag | output | 1 | Last chain completed normally (sticky) |
| err_flag | output | 1 | Last chain aborted on a bus error (sticky) |
| irq | output | 1 | One-cycle completion or abort interrupt |
| fail_desc_addr | output | AW | Address of the descriptor that aborted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |
| bus_req | output | 1 | Bus data cycle request |
| bus_addr_phase | output | 1 | Address is presented on this bus cycle |
| bus_addr | output | AW | Bus source address |
| bus_am | output | 6 | Bus cycle-type code |
| bus_ack | input | 1 | Bus cycle acknowledged, bus_rdata valid |
| bus_err | input | 1 | Bus error; ends the cycle |
| bus_rdata | input | DW | Bus read data |

## Verification
Each bus acknowledge is followed by exactly one memory write on the next cycle. The bench therefore records the address phase and the cycle type at the acknowledge, and it compares them with the queued expected item when that write appears. The first memory read after an accepted go is compared with the head address. busy, done_flag, irq and err_flag change together on the edge after the last write or the error, so the bench samples status on the negative edge after busy falls and checks irq in that same cycle. The flag clearing is checked one cycle after go.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int AMW = 6;
  localparam logic [AMW-1:0] AM_BLOCK = 6'h08;
  localparam int AM_LSB = 16;
  localparam int DESC_WORDS = 4;

  typedef enum logic [1:0] {TS_IDLE, TS_FETCH, TS_MOVE} top_state_t;
  typedef enum logic [1:0] {MV_IDLE, MV_BUS, MV_WRITE} mv_state_t;
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  base,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic [DW-1:0]  rd_data,
  output logic           done,
  output logic [AW-1:0]  src,
  output logic [AW-1:0]  dst,
  output logic [CW-1:0]  count,
  output logic [AMW-1:0] am,
  output logic [AW-1:0]  next,
  output logic           last
);
  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

  logic          active;
  logic [IW-1:0] issue_idx;
  logic          pend;
  logic [IW-1:0] pend_idx;

  assign rd_req  = active;
  assign rd_addr = base + AW'(issue_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      issue_idx <= '0;
      pend      <= 1'b0;
      pend_idx  <= '0;
      done      <= 1'b0;
      src       <= '0;
      dst       <= '0;
      count     <= '0;
      am        <= '0;
      next      <= '0;
      last      <= 1'b0;
    end else begin
      done     <= 1'b0;
      pend     <= active;
      pend_idx <= issue_idx;
      if (start) begin
        active    <= 1'b1;
        issue_idx <= '0;
      end else if (active) begin
        issue_idx <= issue_idx + 1'b1;
        if (issue_idx == LAST_IDX) active <= 1'b0;
      end
      if (pend) begin
        case (pend_idx)
          2'd0: src <= rd_data[AW-1:0];
          2'd1: dst <= rd_data[AW-1:0];
          2'd2: begin
            count <= rd_data[CW-1:0];
            am    <= rd_data[AM_LSB +: AMW];
          end
          default: begin
            next <= rd_data[AW-1:0];
            last <= rd_data[DW-1];
            done <= 1'b1;
          end
        endcase
      end
    end
  end

  // The descriptor is complete two cycles after its last read was issued
  assert_fetch_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rd_req, 2));
endmodule

// File: rtl/dma_word_mover.sv
module dma_word_mover
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  src,
  input  logic [AW-1:0]  dst,
  input  logic [CW-1:0]  count,
  input  logic [AMW-1:0] am,
  output logic           bus_req,
  output logic           bus_addr_phase,
  output logic [AW-1:0]  bus_addr,
  output logic [AMW-1:0] bus_am,
  input  logic           bus_ack,
  input  logic           bus_err,
  input  logic [DW-1:0]  bus_rdata,
  output logic           wr_req,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           done,
  output logic           abort
);
  mv_state_t      state;
  logic [AW-1:0]  src_ptr, dst_ptr;
  logic [CW-1:0]  remaining;
  logic [AMW-1:0] am_q;
  logic [DW-1:0]  data_q;
  logic           first_q;

  assign bus_req        = (state == MV_BUS);
  assign bus_addr       = src_ptr;
  assign bus_am         = am_q;
  assign bus_addr_phase = bus_req && (first_q || (am_q != AM_BLOCK));
  assign wr_req         = (state == MV_WRITE);
  assign wr_addr        = dst_ptr;
  assign wr_data        = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MV_IDLE;
      src_ptr   <= '0;
      dst_ptr   <= '0;
      remaining <= '0;
      am_q      <= '0;
      data_q    <= '0;
      first_q   <= 1'b0;
      done      <= 1'b0;
      abort     <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      case (state)
        MV_IDLE: if (start) begin
          if (count == '0) begin
            done <= 1'b1;
          end else begin
            src_ptr   <= src;
            dst_ptr   <= dst;
            remaining <= count;
            am_q      <= am;
            first_q   <= 1'b1;
            state     <= MV_BUS;
          end
        end
        MV_BUS: begin
          if (bus_err) begin
            abort <= 1'b1;
            state <= MV_IDLE;
          end else if (bus_ack) begin
            data_q <= bus_rdata;
            state  <= MV_WRITE;
          end
        end
        default: begin
          src_ptr   <= src_ptr + 1'b1;
          dst_ptr   <= dst_ptr + 1'b1;
          first_q   <= 1'b0;
          remaining <= remaining - 1'b1;
          if (remaining == CW'(1)) begin
            done  <= 1'b1;
            state <= MV_IDLE;
          end else begin
            state <= MV_BUS;
          end
        end
      endcase
    end
  end

  // A pending bus request holds its address until acknowledged or errored
  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr)));
  // Every memory write follows an acknowledged bus word
  assert_write_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> $past(bus_req && bus_ack));
  // A block-mode word that follows a write presents no address
  assert_block_addr_once_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && (bus_am == AM_BLOCK) && $past(wr_req)) |-> !bus_addr_phase);
  // A bus error ends the transfer without writing the failing word
  assert_err_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_err) |=> (!wr_req && !bus_req && abort));
endmodule

// File: rtl/dma_status.sv
module dma_status #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          finish,
  input  logic          abort,
  input  logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          done_flag,
  output logic          err_flag,
  output logic          irq,
  output logic [AW-1:0] fail_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      irq       <= 1'b0;
      fail_addr <= '0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        done_flag <= 1'b0;
        err_flag  <= 1'b0;
      end else if (abort) begin
        busy      <= 1'b0;
        err_flag  <= 1'b1;
        fail_addr <= cur_addr;
        irq       <= 1'b1;
      end else if (finish) begin
        busy      <= 1'b0;
        done_flag <= 1'b1;
        irq       <= 1'b1;
      end
    end
  end

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_busy_end_irq_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(done_flag && err_flag));
  assert_start_clears_R11: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done_flag && !err_flag && busy));
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [AW-1:0]  head_addr,
  output logic           busy,
  output logic           done_flag,
  output logic           err_flag,
  output logic           irq,
  output logic [AW-1:0]  fail_desc_addr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           bus_req,
  output logic           bus_addr_phase,
  output logic [AW-1:0]  bus_addr,
  output logic [AMW-1:0] bus_am,
  input  logic           bus_ack,
  input  logic           bus_err,
  input  logic [DW-1:0]  bus_rdata
);
  top_state_t     state;
  logic [AW-1:0]  cur_desc;
  logic           fetch_start, move_start;

  logic           f_rd, f_done, f_last;
  logic [AW-1:0]  f_addr, f_src, f_dst, f_next;
  logic [CW-1:0]  f_count;
  logic [AMW-1:0] f_am;

  logic           mv_wr, mv_done, mv_abort;
  logic [AW-1:0]  mv_waddr;
  logic [DW-1:0]  mv_wdata;

  logic go_accept, chain_finish, chain_abort;

  assign go_accept    = go && (state == TS_IDLE);
  assign chain_finish = (state == TS_MOVE) && mv_done && f_last;
  assign chain_abort  = (state == TS_MOVE) && mv_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= TS_IDLE;
      cur_desc    <= '0;
      fetch_start <= 1'b0;
      move_start  <= 1'b0;
    end else begin
      fetch_start <= 1'b0;
      move_start  <= 1'b0;
      case (state)
        TS_IDLE: if (go) begin
          cur_desc    <= head_addr;
          fetch_start <= 1'b1;
          state       <= TS_FETCH;
        end
        TS_FETCH: if (f_done) begin
          move_start <= 1'b1;
          state      <= TS_MOVE;
        end
        default: begin
          if (mv_abort) begin
            state <= TS_IDLE;
          end else if (mv_done) begin
            if (f_last) begin
              state <= TS_IDLE;
            end else begin
              cur_desc    <= f_next;
              fetch_start <= 1'b1;
              state       <= TS_FETCH;
            end
          end
        end
      endcase
    end
  end

  dma_desc_fetch #(.AW(AW), .DW(DW), .CW(CW)) u_fetch (
    .clk(clk), .rst(rst), .start(fetch_start), .base(cur_desc),
    .rd_req(f_rd), .rd_addr(f_addr), .rd_data(mem_rdata), .done(f_done),
    .src(f_src), .dst(f_dst), .count(f_count), .am(f_am),
    .next(f_next), .last(f_last)
  );

  dma_word_mover #(.AW(AW), .DW(DW), .CW(CW)) u_mover (
    .clk(clk), .rst(rst), .start(move_start),
    .src(f_src), .dst(f_dst), .count(f_count), .am(f_am),
    .bus_req(bus_req), .bus_addr_phase(bus_addr_phase), .bus_addr(bus_addr),
    .bus_am(bus_am), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .wr_req(mv_wr), .wr_addr(mv_waddr), .wr_data(mv_wdata),
    .done(mv_done), .abort(mv_abort)
  );

  dma_status #(.AW(AW)) u_status (
    .clk(clk), .rst(rst), .start(go_accept), .finish(chain_finish),
    .abort(chain_abort), .cur_addr(cur_desc),
    .busy(busy), .done_flag(done_flag), .err_flag(err_flag), .irq(irq),
    .fail_addr(fail_desc_addr)
  );

  assign mem_req   = f_rd | mv_wr;
  assign mem_we    = mv_wr;
  assign mem_addr  = mv_wr ? mv_waddr : f_addr;
  assign mem_wdata = mv_wdata;

  // Descriptor reads and data writes never collide on the shared port
  assert_port_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(f_rd && mv_wr));
  // A go while busy leaves the current descriptor pointer alone
  assert_go_busy_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && go && (state == TS_FETCH)) |=> $stable(cur_desc));
  // The fetch unit is only started once the engine has left idle
  assert_no_fetch_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (state == TS_IDLE && !go) |=> !f_rd);
endmodule

// File: tb/tb_desc_chain_dma.sv
module tb_desc_chain_dma;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic go = 1'b0;
  logic [AW-1:0] head_addr = '0;
  logic busy, done_flag, err_flag, irq;
  logic [AW-1:0] fail_desc_addr;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic bus_req, bus_addr_phase;
  logic [AW-1:0] bus_addr;
  logic [5:0] bus_am;
  logic bus_ack, bus_err;
  logic [DW-1:0] bus_rdata;

  desc_chain_dma #(.AW(AW), .DW(DW), .CW(16)) dut (.*);

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model (1-cycle read latency) -------------
  logic [DW-1:0] mem [0:255];
  logic          ld_en = 1'b0;
  logic [7:0]    ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic load(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a[7:0]; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // ---------------- bus slave model --------------------------------
  logic [AW-1:0] err_src = 16'hFFFF;
  logic [1:0]    wcnt;

  function automatic logic [DW-1:0] src_word(input logic [AW-1:0] a);
    return {16'hB00C ^ {a[7:0], a[15:8]}, a};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; bus_err <= 1'b0; wcnt <= '0; bus_rdata <= '0;
    end else if (bus_ack || bus_err) begin
      bus_ack <= 1'b0; bus_err <= 1'b0; wcnt <= '0;
    end else if (bus_req) begin
      if (wcnt == bus_addr[1:0]) begin
        if (bus_addr == err_src) bus_err <= 1'b1;
        else bus_ack <= 1'b1;
        bus_rdata <= src_word(bus_addr);
      end else wcnt <= wcnt + 1'b1;
    end
  end

  // ---------------- scoreboard --------------------------------------
  typedef struct {
    logic [AW-1:0] dst;
    logic [DW-1:0] data;
    logic          phase;
    logic [5:0]    am;
  } exp_t;
  exp_t sbq[$];

  int irq_count = 0;
  int ack_count = 0;
  logic seen_phase;
  logic [5:0] seen_am;
  logic prev_busy = 1'b0;
  logic want_head = 1'b0;
  logic [AW-1:0] exp_head = '0;

  // Driver: write one descriptor and queue the writes it should produce
  task automatic put_desc(input int at, input logic [AW-1:0] src,
                          input logic [AW-1:0] dst, input logic [5:0] am,
                          input int cnt, input logic [AW-1:0] nxt,
                          input bit last, input int ok_words);
    load(at,     {16'h0, src});
    load(at + 1, {16'h0, dst});
    load(at + 2, {10'h0, am, cnt[15:0]});
    load(at + 3, {last, 15'h0, nxt});
    for (int i = 0; i < ok_words; i++) begin
      exp_t e;
      e.dst   = dst + AW'(i);
      e.data  = src_word(src + AW'(i));
      e.phase = (am == 6'h08) ? (i == 0) : 1'b1;
      e.am    = am;
      sbq.push_back(e);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && bus_ack) begin
        seen_phase = bus_addr_phase;
        seen_am    = bus_am;
        ack_count++;
      end
      if (mem_req && !mem_we && want_head) begin
        check(mem_addr == exp_head, "R2", "first descriptor read address",
              mem_addr, exp_head);
        want_head = 1'b0;
      end
      if (mem_req && mem_we) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R6", "unexpected memory write", mem_addr, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(mem_addr == e.dst, "R4", "write address", mem_addr, e.dst);
          check(mem_wdata == e.data, "R4", "write data", mem_wdata, e.data);
          check(seen_am == e.am, "R3", "cycle type on bus", seen_am, e.am);
          check(seen_phase == e.phase, "R5", "address phase", seen_phase, e.phase);
        end
      end
      if (irq) irq_count++;
      if (prev_busy && !busy)
        check(irq == 1'b1, "R8", "irq with busy fall", irq, 1);
      prev_busy = busy;
    end
  end

  // ---------------- watchdog ----------------------------------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic start_chain(input logic [AW-1:0] h);
    @(negedge clk);
    exp_head = h; want_head = 1'b1;
    head_addr = h; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!busy && !done_flag && !err_flag && !irq, "R1", "status after reset",
          {busy, done_flag, err_flag, irq}, 0);
    check(!bus_req && !mem_req, "R1", "requests after reset",
          {bus_req, mem_req}, 0);

    for (int i = 8'h80; i < 8'hE0; i++) load(i, 32'hDEAD_0000 | i);

    // Chain A: single cycles, block mode, zero count, block mode last
    put_desc(8'h10, 16'h1000, 16'h0080, 6'h09, 3, 16'h0020, 1'b0, 3);
    put_desc(8'h20, 16'h2000, 16'h0090, 6'h08, 4, 16'h0030, 1'b0, 4);
    put_desc(8'h30, 16'h3000, 16'h00A0, 6'h09, 0, 16'h0040, 1'b0, 0);
    put_desc(8'h40, 16'h4000, 16'h00A8, 6'h08, 2, 16'h0000, 1'b1, 2);
    // Decoy chain that must never run (R10); written to memory only
    load(8'h50, 32'h5000); load(8'h51, 32'hB0);
    load(8'h52, 32'h0009_0005); load(8'h53, 32'h8000_0000);

    start_chain(16'h0010);
    repeat (6) @(negedge clk);
    head_addr = 16'h0050; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b1, "R10", "busy after go while busy", busy, 1);
    wait_idle();
    check(done_flag == 1'b1, "R8", "done flag after chain", done_flag, 1);
    check(err_flag == 1'b0, "R8", "no error after chain", err_flag, 0);
    check(irq_count == 1, "R8", "one irq pulse", irq_count, 1);
    check(sbq.size() == 0, "R6", "all chain writes seen", sbq.size(), 0);
    check(ack_count == 9, "R7", "bus words for chain", ack_count, 9);
    check(mem[8'hA0] == 32'hDEAD_00A0, "R7", "zero-count destination untouched",
          mem[8'hA0], 32'hDEAD_00A0);
    check(mem[8'hB0] == 32'hDEAD_00B0, "R10", "decoy destination untouched",
          mem[8'hB0], 32'hDEAD_00B0);

    // Chain B: bus error on second word of second descriptor
    err_src = 16'h7001;
    put_desc(8'h60, 16'h6000, 16'h00B8, 6'h09, 2, 16'h0068, 1'b0, 2);
    put_desc(8'h68, 16'h7000, 16'h00C0, 6'h08, 3, 16'h0070, 1'b0, 1);
    put_desc(8'h70, 16'h7100, 16'h00C8, 6'h09, 1, 16'h0000, 1'b1, 0);
    start_chain(16'h0060);
    check(done_flag == 1'b0, "R11", "done cleared by go", done_flag, 0);
    wait_idle();
    check(err_flag == 1'b1, "R9", "error flag", err_flag, 1);
    check(done_flag == 1'b0, "R11", "done stays clear on abort", done_flag, 0);
    check(fail_desc_addr == 16'h0068, "R9", "failing descriptor address",
          fail_desc_addr, 16'h0068);
    check(irq_count == 2, "R9", "irq on abort", irq_count, 2);
    check(sbq.size() == 0, "R9", "writes before error", sbq.size(), 0);
    check(mem[8'hC1] == 32'hDEAD_00C1, "R9", "failing word not written",
          mem[8'hC1], 32'hDEAD_00C1);
    check(mem[8'hC8] == 32'hDEAD_00C8, "R9", "later descriptor not run",
          mem[8'hC8], 32'hDEAD_00C8);

    // Chain C: single end-marked block descriptor after an error
    err_src = 16'hFFFF;
    put_desc(8'h78, 16'h8000, 16'h00D0, 6'h08, 1, 16'h0000, 1'b1, 1);
    start_chain(16'h0078);
    check(err_flag == 1'b0, "R11", "error cleared by go", err_flag, 0);
    wait_idle();
    check(done_flag == 1'b1, "R6", "single descriptor chain done", done_flag, 1);
    check(mem[8'hD0] == src_word(16'h8000), "R4", "copied word in memory",
          mem[8'hD0], src_word(16'h8000));
    check(irq_count == 3, "R8", "irq count after third chain", irq_count, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule